// File: doc/BRIEF.md
# Exception Entry and Cause Unit

This unit records how a processor enters an exception. When a request arrives with a 5-bit exception code, the unit decides whether the request is accepted. Interrupts are accepted only when the global enable is set and no exception is already being handled. All other codes are always accepted. On acceptance it stores the cause code and raises the exception-level flag. While that flag was clear, it also captures the restart address and the branch-delay marker. For a misaligned load address it additionally latches the faulting address.

A free-running event counter is included. It steps on each timer tick and raises a pending timer interrupt bit in the cause word when it reaches a programmable match value. The pending bit is dropped only when software writes the match value. A small write port lets software load the status bits, the counter and the match value. Every output comes straight from a flip-flop.

Top module: `exc_entry_unit`

## Requirements
- R1: After a synchronous reset, exc_taken, status_o, cause_o, epc_o, badvaddr_o, count_o and compare_o all read zero.
- R2: A request with a nonzero code is always accepted. exc_taken is high for exactly the one cycle after the clock edge that sampled the request. The code appears in cause_o bits 6:2, and status_o bit 1 (exception level, EXL) reads 1.
- R3: A request with code 0 (interrupt) is accepted only when status_o bit 0 (interrupt enable, IE) is 1 and EXL is 0. Otherwise exc_taken stays low and cause_o, epc_o and status_o keep their values.
- R4: An accepted request with EXL clear and exc_in_slot low loads epc_o with exc_pc with its two low bits cleared, and clears cause_o bit 31 (branch-delay flag, BD).
- R5: An accepted request with EXL clear and exc_in_slot high loads epc_o with the word-aligned exc_pc minus 4, and sets cause_o bit 31.
- R6: An accepted request while EXL is already 1 leaves epc_o and cause_o bit 31 unchanged, but still updates cause_o bits 6:2.
- R7: Cause bit 15 is the pending timer interrupt. A code update leaves it unchanged. All cause bits other than 31, 15 and 6:2 read zero.
- R8: An accepted request with code 4 (address error on load) copies exc_bad_addr into badvaddr_o. Any other code leaves badvaddr_o unchanged.
- R9: With wr_en high, wr_sel selects the target: 0 = status (wr_data bit 0 to IE, bit 1 to EXL), 1 = counter, 2 = match value. When a status write and an accepted request fall in the same cycle, the request wins for EXL, so EXL reads 1.
- R10: Each cycle with timer_tick high adds 1 to count_o. A counter write in the same cycle wins over the tick.
- R11: When a tick brings the counter to a value equal to compare_o, cause_o bit 15 becomes 1 in the same update. It stays 1 through further ticks.
- R12: A write to the match value clears cause_o bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request, one cycle |
| exc_code | input | 5 | Exception code of the request |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_in_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_bad_addr | input | 32 | Offending data address for code 4 |
| timer_tick | input | 1 | Counter increment strobe |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 2 | Write target: 0 status, 1 counter, 2 match value |
| wr_data | input | 32 | Write data |
| exc_taken | output | 1 | One-cycle pulse for an accepted request |
| status_o | output | 32 | Bit 0 IE, bit 1 EXL, others zero |
| cause_o | output | 32 | Bit 31 BD, bit 15 timer pending, bits 6:2 code |
| epc_o | output | 32 | Captured restart address |
| badvaddr_o | output | 32 | Captured faulting data address |
| count_o | output | 32 | Event counter |
| compare_o | output | 32 | Counter match value |

## Verification
If the exception-level flag were wrong, it would show up the cycle after the next request. A spurious EXL would freeze epc_o and bit 31 across an exception that should have moved them. A missing EXL would let a gated interrupt pulse exc_taken. A corrupted acceptance decision or code field is visible one cycle after the request edge, on exc_taken and cause_o bits 6:2. A counter off by one is visible in count_o after a single tick, and it moves the cycle in which cause_o bit 15 rises relative to the tick that reaches the match value.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN    = 32;
  localparam int CODE_W  = 5;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS  = 2'd0,
    SEL_COUNT   = 2'd1,
    SEL_COMPARE = 2'd2,
    SEL_NONE    = 2'd3
  } wsel_e;
endpackage

// File: rtl/exc_status_cause.sv
module exc_status_cause
  import exc_pkg::*;
#(
  parameter int W          = 32,
  parameter int CW         = 5,
  parameter int INT_CODE   = 0,
  parameter int ADEL_CODE  = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exc_req,
  input  logic [CW-1:0] exc_code,
  input  logic [W-1:0]  exc_pc,
  input  logic          exc_in_slot,
  input  logic [W-1:0]  exc_bad_addr,
  input  logic          status_wr,
  input  logic [W-1:0]  wr_data,
  output logic          taken_q,
  output logic          ie_q,
  output logic          exl_q,
  output logic          bd_q,
  output logic [CW-1:0] code_q,
  output logic [W-1:0]  epc_q,
  output logic [W-1:0]  badaddr_q
);
  localparam int ALIGN_W = $clog2(WORD_BYTES);

  logic         is_int;
  logic         accept;
  logic [W-1:0] aligned_pc;
  logic [W-1:0] restart_pc;

  always_comb begin
    is_int     = (exc_code == CW'(INT_CODE));
    accept     = exc_req && (!is_int || (ie_q && !exl_q));
    aligned_pc = {exc_pc[W-1:ALIGN_W], ALIGN_W'(0)};
    restart_pc = exc_in_slot ? (aligned_pc - W'(WORD_BYTES)) : aligned_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q   <= 1'b0;
      ie_q      <= 1'b0;
      exl_q     <= 1'b0;
      bd_q      <= 1'b0;
      code_q    <= '0;
      epc_q     <= '0;
      badaddr_q <= '0;
    end else begin
      taken_q <= accept;
      if (status_wr) begin
        ie_q  <= wr_data[0];
        exl_q <= wr_data[1];
      end
      if (accept) begin
        exl_q  <= 1'b1;
        code_q <= exc_code;
        if (!exl_q) begin
          bd_q  <= exc_in_slot;
          epc_q <= restart_pc;
        end
        if (exc_code == CW'(ADEL_CODE)) badaddr_q <= exc_bad_addr;
      end
    end
  end

  // R3: gated interrupt never produces a pulse
  a_r3_int_gated: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_code == CW'(INT_CODE) && (!ie_q || exl_q)) |=> !taken_q);
  // R2: non-interrupt code always accepted
  a_r2_code_taken: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_code != CW'(INT_CODE)) |=> taken_q);
  // R2: accepted exception leaves EXL raised
  a_r2_exl_set: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> exl_q);
  // R6: EPC and BD frozen while nested
  a_r6_epc_hold: assert property (@(posedge clk) disable iff (rst)
    (taken_q && $past(exl_q)) |-> (epc_q == $past(epc_q) && bd_q == $past(bd_q)));
  // R8: only an address-error-on-load capture moves BadVAddr
  a_r8_badaddr_hold: assert property (@(posedge clk) disable iff (rst)
    (exc_code != CW'(ADEL_CODE)) |=> $stable(badaddr_q));
endmodule

// File: rtl/exc_count_timer.sv
module exc_count_timer
  import exc_pkg::*;
#(
  parameter int W       = 32,
  parameter int COUNT_W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         count_wr,
  input  logic         compare_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_o,
  output logic [W-1:0] compare_o,
  output logic         pend_q
);
  logic [COUNT_W-1:0] count_q;
  logic [COUNT_W-1:0] compare_q;
  logic [COUNT_W-1:0] next_count;

  always_comb next_count = count_q + COUNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      compare_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (count_wr)  count_q <= wr_data[COUNT_W-1:0];
      else if (tick) count_q <= next_count;
      if (compare_wr) begin
        compare_q <= wr_data[COUNT_W-1:0];
        pend_q    <= 1'b0;
      end else if (tick && !count_wr && next_count == compare_q) begin
        pend_q <= 1'b1;
      end
    end
  end

  generate
    if (COUNT_W < W) begin : g_ext
      assign count_o   = {{(W-COUNT_W){1'b0}}, count_q};
      assign compare_o = {{(W-COUNT_W){1'b0}}, compare_q};
    end else begin : g_full
      assign count_o   = count_q[W-1:0];
      assign compare_o = compare_q[W-1:0];
    end
  endgenerate

  // R10: tick steps counter by one unless written
  a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !count_wr) |=> count_q == $past(count_q) + COUNT_W'(1));
  // R12: match write clears pending
  a_r12_pend_clear: assert property (@(posedge clk) disable iff (rst)
    compare_wr |=> !pend_q);
  // R11: pending, once set, holds without a match write
  a_r11_pend_sticky: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !compare_wr) |=> pend_q);
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int W          = 32,
  parameter int CW         = 5,
  parameter int COUNT_W    = 32,
  parameter int INT_CODE   = 0,
  parameter int ADEL_CODE  = 4,
  parameter int WORD_BYTES = 4,
  parameter int TIMER_LINE = 7,
  parameter int IP_BASE    = 8,
  parameter int CODE_LSB   = 2,
  parameter int BD_BIT     = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exc_req,
  input  logic [CW-1:0] exc_code,
  input  logic [W-1:0]  exc_pc,
  input  logic          exc_in_slot,
  input  logic [W-1:0]  exc_bad_addr,
  input  logic          timer_tick,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [W-1:0]  wr_data,
  output logic          exc_taken,
  output logic [W-1:0]  status_o,
  output logic [W-1:0]  cause_o,
  output logic [W-1:0]  epc_o,
  output logic [W-1:0]  badvaddr_o,
  output logic [W-1:0]  count_o,
  output logic [W-1:0]  compare_o
);
  localparam int PEND_BIT = IP_BASE + TIMER_LINE;

  logic          status_wr, count_wr, compare_wr;
  logic          ie, exl, bd, pend;
  logic [CW-1:0] code;

  always_comb begin
    status_wr  = wr_en && (wr_sel == SEL_STATUS);
    count_wr   = wr_en && (wr_sel == SEL_COUNT);
    compare_wr = wr_en && (wr_sel == SEL_COMPARE);
  end

  exc_status_cause #(
    .W(W), .CW(CW), .INT_CODE(INT_CODE), .ADEL_CODE(ADEL_CODE), .WORD_BYTES(WORD_BYTES)
  ) sc_i (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code), .exc_pc(exc_pc),
    .exc_in_slot(exc_in_slot), .exc_bad_addr(exc_bad_addr), .status_wr(status_wr),
    .wr_data(wr_data), .taken_q(exc_taken), .ie_q(ie), .exl_q(exl), .bd_q(bd),
    .code_q(code), .epc_q(epc_o), .badaddr_q(badvaddr_o)
  );

  exc_count_timer #(.W(W), .COUNT_W(COUNT_W)) tm_i (
    .clk(clk), .rst(rst), .tick(timer_tick), .count_wr(count_wr),
    .compare_wr(compare_wr), .wr_data(wr_data), .count_o(count_o),
    .compare_o(compare_o), .pend_q(pend)
  );

  always_comb begin
    status_o    = '0;
    status_o[0] = ie;
    status_o[1] = exl;
    cause_o                   = '0;
    cause_o[BD_BIT]           = bd;
    cause_o[PEND_BIT]         = pend;
    cause_o[CODE_LSB +: CW]   = code;
  end

  // R7: code update never disturbs the timer pending bit
  a_r7_pend_kept: assert property (@(posedge clk) disable iff (rst)
    (exc_req && !compare_wr) |=> (cause_o[PEND_BIT] || !$past(cause_o[PEND_BIT])));
endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic        exc_in_slot = 1'b0;
  logic [31:0] exc_bad_addr = '0;
  logic        timer_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        exc_taken;
  logic [31:0] status_o, cause_o, epc_o, badvaddr_o, count_o, compare_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  exc_entry_unit dut_i (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code), .exc_pc(exc_pc),
    .exc_in_slot(exc_in_slot), .exc_bad_addr(exc_bad_addr), .timer_tick(timer_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .exc_taken(exc_taken),
    .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o), .badvaddr_o(badvaddr_o),
    .count_o(count_o), .compare_o(compare_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic raise(input logic [4:0] code, input logic [31:0] pc,
                       input logic slot, input logic [31:0] bad);
    exc_req = 1'b1; exc_code = code; exc_pc = pc; exc_in_slot = slot; exc_bad_addr = bad;
    step();
    exc_req = 1'b0; exc_in_slot = 1'b0;
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    step();
    wr_en = 1'b0;
  endtask

  task automatic tick_once();
    timer_tick = 1'b1;
    step();
    timer_tick = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step(); rst = 1'b0; step();
    check("R1 taken", {31'b0, exc_taken}, 32'h0);
    check("R1 status", status_o, 32'h0);
    check("R1 cause", cause_o, 32'h0);
    check("R1 epc", epc_o, 32'h0);
    check("R1 badvaddr", badvaddr_o, 32'h0);
    check("R1 count", count_o, 32'h0);
    check("R1 compare", compare_o, 32'h0);
  endtask

  task automatic t_plain();
    raise(5'd8, 32'h0040_0013, 1'b0, 32'h0);
    check("R2 pulse", {31'b0, exc_taken}, 32'h1);
    check("R2 code", cause_o, 32'h0000_0020);
    check("R2 exl", status_o, 32'h2);
    check("R4 epc aligned", epc_o, 32'h0040_0010);
    step();
    check("R2 pulse ends", {31'b0, exc_taken}, 32'h0);
  endtask

  task automatic t_nested();
    raise(5'd10, 32'h0000_1000, 1'b1, 32'h0);
    check("R6 taken", {31'b0, exc_taken}, 32'h1);
    check("R6 epc held", epc_o, 32'h0040_0010);
    check("R6 bd held code new", cause_o, 32'h0000_0028);
  endtask

  task automatic t_slot();
    sw_write(2'd0, 32'h0);
    raise(5'd12, 32'h0040_1002, 1'b1, 32'h0);
    check("R5 epc", epc_o, 32'h0040_0FFC);
    check("R5 bd", cause_o, 32'h8000_0030);
  endtask

  task automatic t_interrupt();
    raise(5'd0, 32'h0000_3000, 1'b0, 32'h0);
    check("R3 ie0 no pulse", {31'b0, exc_taken}, 32'h0);
    check("R3 ie0 cause kept", cause_o, 32'h8000_0030);
    sw_write(2'd0, 32'h3);
    raise(5'd0, 32'h0000_3000, 1'b0, 32'h0);
    check("R3 exl1 no pulse", {31'b0, exc_taken}, 32'h0);
    check("R3 exl1 epc kept", epc_o, 32'h0040_0FFC);
    sw_write(2'd0, 32'h1);
    check("R9 status write", status_o, 32'h1);
    raise(5'd0, 32'h0000_2000, 1'b0, 32'h0);
    check("R3 enabled pulse", {31'b0, exc_taken}, 32'h1);
    check("R4 int epc", epc_o, 32'h0000_2000);
    check("R4 bd cleared", cause_o, 32'h0000_0000);
    check("R3 status after", status_o, 32'h3);
  endtask

  task automatic t_badaddr();
    sw_write(2'd0, 32'h0);
    raise(5'd4, 32'h0000_0100, 1'b0, 32'hDEAD_BEE1);
    check("R8 capture", badvaddr_o, 32'hDEAD_BEE1);
    raise(5'd5, 32'h0000_0100, 1'b0, 32'h0000_1234);
    check("R8 other code kept", badvaddr_o, 32'hDEAD_BEE1);
  endtask

  task automatic t_collision();
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0;
    raise(5'd9, 32'h0000_0200, 1'b0, 32'h0);
    wr_en = 1'b0;
    check("R9 exception wins exl", status_o, 32'h2);
  endtask

  task automatic t_timer();
    sw_write(2'd1, 32'h0);
    sw_write(2'd2, 32'h3);
    check("R9 compare write", compare_o, 32'h3);
    tick_once();
    check("R10 count 1", count_o, 32'h1);
    check("R11 not yet", {31'b0, cause_o[15]}, 32'h0);
    tick_once();
    check("R11 still not", {31'b0, cause_o[15]}, 32'h0);
    tick_once();
    check("R10 count 3", count_o, 32'h3);
    check("R11 match pend", {31'b0, cause_o[15]}, 32'h1);
    tick_once();
    check("R11 sticky", {31'b0, cause_o[15]}, 32'h1);
    raise(5'd8, 32'h0000_0400, 1'b0, 32'h0);
    check("R7 pend kept", cause_o & 32'h0000_807C, 32'h0000_8020);
    timer_tick = 1'b1;
    sw_write(2'd1, 32'h100);
    timer_tick = 1'b0;
    check("R10 write wins", count_o, 32'h100);
    sw_write(2'd2, 32'hA);
    check("R12 pend cleared", {31'b0, cause_o[15]}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_nested();
    t_slot();
    t_interrupt();
    t_badaddr();
    t_collision();
    t_timer();
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule